// File: doc/BRIEF.md
# Quasi-Bidirectional Port Driver Controller

This block controls the pad drivers of an 8-bit general-purpose port in which every pin is both an output and an input without any direction register. Software writes a port latch. For each pin the block derives three driver enables: a weak sustaining pull-up, a strong pull-down and a short strong pull-up. A pin whose latch holds 1 is held high only by the weak pull-up. An external circuit can therefore pull it low, and software reads the pin level back as an input.

The strong pull-up fires only when a pin's drive value goes from 0 to 1. It lasts a fixed number of clocks and speeds up the rising edge. An override per pin lets a peripheral output share the pin: the drive value becomes the AND of the latch bit and the peripheral output, and the same driver rules apply. Pin levels come back through a synchroniser. That synchronised level also feeds an edge detector per pin. Even-numbered pins flag rising edges and odd-numbered pins flag falling edges, for use as external interrupt sources.

Top module: `qbp_port`

## Requirements
- R1: After reset, latch_rd is all ones, weak_pu is all ones, strong_pd and strong_pu are all zeros, pin_rd is all ones and pin_evt is all zeros.
- R2: A pin whose drive value is 1 and whose strong pull-up pulse has ended has only weak_pu set, so its pin_rd bit follows pad_in.
- R3: A pin whose drive value is 0 has strong_pd set and weak_pu clear. This state holds for as long as the latch bit stays 0.
- R4: When a pin's drive value changes from 0 to 1, strong_pu for that pin is set for exactly PULSE_CYCLES (default 2) clocks. The pulse starts in the cycle in which the new drive value first appears.
- R5: Writing 1 to a latch bit that already holds 1 produces no strong_pu pulse.
- R6: strong_pu and strong_pd are never both set on the same pin.
- R7: pin_rd returns pad_in delayed by SYNC_STAGES (default 2) clocks, whatever the latch holds. latch_rd returns the latch contents, for read-modify-write use.
- R8: A write with wr_en high loads wr_data only into the bits whose wr_mask bit is 1. All other latch bits are left unchanged, and with wr_en low the latch holds.
- R9: For a pin whose alt_en bit is 1, the drive value is latch bit AND alt_out bit. For other pins it is the latch bit. The alternate drive value follows the rules of R2 to R5.
- R10: pin_evt[i] is high for exactly one clock when pin_rd[i] rises (i even) or falls (i odd). It is high in the first cycle in which pin_rd shows the new level.
- R11: If the drive value returns to 0 during a strong pull-up pulse, strong_pu clears and strong_pd sets in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Latch write strobe |
| wr_mask | input | WIDTH | Per-bit write enable for a latch write |
| wr_data | input | WIDTH | Data written into the latch |
| alt_en | input | WIDTH | Per-pin peripheral override enable |
| alt_out | input | WIDTH | Peripheral output value per pin |
| pad_in | input | WIDTH | Raw pad input levels |
| latch_rd | output | WIDTH | Current latch contents |
| pin_rd | output | WIDTH | Synchronised pad levels |
| weak_pu | output | WIDTH | Weak pull-up enable |
| strong_pd | output | WIDTH | Strong pull-down enable |
| strong_pu | output | WIDTH | Momentary strong pull-up enable |
| pin_evt | output | WIDTH | Edge event per pin (even pins rising, odd pins falling) |

## Verification
The drivers are tried with four kinds of latch write:
- Masked writes of 0 show that the pull-down stays on and that unmasked bits are left alone.
- Writes of 1 over 0 show the pulse length and the cycle in which it starts.
- Writes of 1 over 1 show that a level alone does not start a pulse.
- A 1 followed at once by a 0 shows that the pulse is cut short.

The peripheral override is driven low and then high with the latch at 1. This shows that the pulse follows the ANDed drive value rather than the latch. On the input side, a pad pattern with mixed rising and falling bits tells the even-pin detectors from the odd-pin ones. It also shows that pin_rd follows the pads while the latch stays unchanged.

// File: rtl/qbp_pkg.sv
package qbp_pkg;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_pol_e;

  // Interrupt polarity alternates across neighbouring pins.
  function automatic edge_pol_e pol_for_pin(input int idx);
    return (idx % 2 == 0) ? EDGE_RISE : EDGE_FALL;
  endfunction

endpackage

// File: rtl/qbp_sync.sv
module qbp_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] chain_q [STAGES];
  logic [WIDTH-1:0] chain_d [STAGES];

  always_comb begin
    chain_d[0] = d;
    for (int s = 1; s < STAGES; s++) begin
      chain_d[s] = chain_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) begin
        chain_q[s] <= '1;
      end
    end else begin
      for (int s = 0; s < STAGES; s++) begin
        chain_q[s] <= chain_d[s];
      end
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/qbp_pin_drv.sv
module qbp_pin_drv #(
  parameter int PULSE_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drive_hi,
  output logic weak_pu,
  output logic strong_pd,
  output logic strong_pu
);

  localparam int             CW     = $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0]  RELOAD = CW'(PULSE_CYCLES - 1);

  logic          prev_q, prev_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          rise;

  assign rise = drive_hi & ~prev_q;

  always_comb begin
    prev_d = drive_hi;
    cnt_d  = cnt_q;
    if (!drive_hi) begin
      cnt_d = '0;
    end else if (rise) begin
      cnt_d = RELOAD;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      prev_q <= prev_d;
      cnt_q  <= cnt_d;
    end
  end

  assign weak_pu   = drive_hi;
  assign strong_pd = ~drive_hi;
  assign strong_pu = drive_hi & (rise | (cnt_q != '0));

endmodule

// File: rtl/qbp_edge_det.sv
module qbp_edge_det #(
  parameter qbp_pkg::edge_pol_e POL = qbp_pkg::EDGE_RISE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic evt
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
    end else begin
      prev_q <= lvl;
    end
  end

  generate
    if (POL == qbp_pkg::EDGE_RISE) begin : g_rise
      assign evt = lvl & ~prev_q;
    end else begin : g_fall
      assign evt = ~lvl & prev_q;
    end
  endgenerate

endmodule

// File: rtl/qbp_port.sv
module qbp_port #(
  parameter int WIDTH        = 8,
  parameter int PULSE_CYCLES = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_mask,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] alt_en,
  input  logic [WIDTH-1:0] alt_out,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] latch_rd,
  output logic [WIDTH-1:0] pin_rd,
  output logic [WIDTH-1:0] weak_pu,
  output logic [WIDTH-1:0] strong_pd,
  output logic [WIDTH-1:0] strong_pu,
  output logic [WIDTH-1:0] pin_evt
);

  logic [WIDTH-1:0] latch_q, latch_d;
  logic [WIDTH-1:0] drive_hi;

  always_comb begin
    latch_d = latch_q;
    if (wr_en) begin
      latch_d = (latch_q & ~wr_mask) | (wr_data & wr_mask);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '1;
    end else begin
      latch_q <= latch_d;
    end
  end

  assign latch_rd = latch_q;
  assign drive_hi = latch_q & (~alt_en | alt_out);

  qbp_sync #(
    .WIDTH  (WIDTH),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_rd)
  );

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      qbp_pin_drv #(
        .PULSE_CYCLES (PULSE_CYCLES)
      ) u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .drive_hi  (drive_hi[i]),
        .weak_pu   (weak_pu[i]),
        .strong_pd (strong_pd[i]),
        .strong_pu (strong_pu[i])
      );

      qbp_edge_det #(
        .POL (qbp_pkg::pol_for_pin(i))
      ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (pin_rd[i]),
        .evt   (pin_evt[i])
      );
    end
  endgenerate

endmodule

// File: rtl/qbp_port_chk.sv
module qbp_port_chk #(
  parameter int WIDTH        = 8,
  parameter int PULSE_CYCLES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [WIDTH-1:0] wr_mask,
  input logic [WIDTH-1:0] latch_rd,
  input logic [WIDTH-1:0] pin_rd,
  input logic [WIDTH-1:0] weak_pu,
  input logic [WIDTH-1:0] strong_pd,
  input logic [WIDTH-1:0] strong_pu,
  input logic [WIDTH-1:0] pin_evt
);

  localparam int RW = $clog2(PULSE_CYCLES + 2);

  p_no_fight_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strong_pu & strong_pd) == '0);

  p_weak_vs_pd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    weak_pu == ~strong_pd);

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> latch_rd == $past(latch_rd));

  p_masked_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((latch_rd ^ $past(latch_rd)) & ~$past(wr_mask)) == '0);

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      localparam logic RISE_PIN = (i % 2 == 0);
      logic [RW-1:0] run_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          run_q <= '0;
        end else if (!strong_pu[i]) begin
          run_q <= '0;
        end else if (run_q <= RW'(PULSE_CYCLES)) begin
          run_q <= run_q + 1'b1;
        end
      end

      p_pulse_after_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strong_pu[i]) |-> $past(strong_pd[i]));

      p_pulse_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RW'(PULSE_CYCLES));

      p_evt_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pin_evt[i] |-> (pin_rd[i] != $past(pin_rd[i])) && (pin_rd[i] == RISE_PIN));
    end
  endgenerate

endmodule

bind qbp_port qbp_port_chk #(
  .WIDTH        (WIDTH),
  .PULSE_CYCLES (PULSE_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_mask   (wr_mask),
  .latch_rd  (latch_rd),
  .pin_rd    (pin_rd),
  .weak_pu   (weak_pu),
  .strong_pd (strong_pd),
  .strong_pu (strong_pu),
  .pin_evt   (pin_evt)
);

// File: tb/qbp_port_test.sv
module qbp_port_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_mask, wr_data, alt_en, alt_out, pad_in;
  logic [7:0] latch_rd, pin_rd, weak_pu, strong_pd, strong_pu, pin_evt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qbp_port uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_mask   (wr_mask),
    .wr_data   (wr_data),
    .alt_en    (alt_en),
    .alt_out   (alt_out),
    .pad_in    (pad_in),
    .latch_rd  (latch_rd),
    .pin_rd    (pin_rd),
    .weak_pu   (weak_pu),
    .strong_pd (strong_pd),
    .strong_pu (strong_pu),
    .pin_evt   (pin_evt)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // Write at the next edge; returns at the negedge right after it.
  task automatic write_port(input logic [7:0] mask, input logic [7:0] data);
    wr_en = 1'b1; wr_mask = mask; wr_data = data;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    check8("R1 latch_rd", latch_rd, 8'hFF);
    check8("R1 weak_pu", weak_pu, 8'hFF);
    check8("R1 strong_pd", strong_pd, 8'h00);
    check8("R1 strong_pu", strong_pu, 8'h00);
    check8("R1 pin_rd", pin_rd, 8'hFF);
    check8("R1 pin_evt", pin_evt, 8'h00);
  endtask

  task automatic t_write_low;
    write_port(8'h0F, 8'h00);
    check8("R8 masked latch", latch_rd, 8'hF0);
    check8("R3 strong_pd on", strong_pd, 8'h0F);
    check8("R3 weak_pu off", weak_pu, 8'hF0);
    check8("R6 no pulse on low", strong_pu, 8'h00);
    repeat (5) @(negedge clk);
    check8("R3 pd held", strong_pd, 8'h0F);
    check8("R8 idle latch", latch_rd, 8'hF0);
  endtask

  task automatic t_pulse;
    write_port(8'h01, 8'h01);
    check8("R4 pulse cycle 1", strong_pu, 8'h01);
    @(negedge clk);
    check8("R4 pulse cycle 2", strong_pu, 8'h01);
    @(negedge clk);
    check8("R4 pulse ended", strong_pu, 8'h00);
    check8("R2 weak only", weak_pu, 8'hF1);
    check8("R3 others still low", strong_pd, 8'h0E);
  endtask

  task automatic t_no_pulse;
    write_port(8'hF0, 8'hF0);
    check8("R5 no pulse 1", strong_pu, 8'h00);
    @(negedge clk);
    check8("R5 no pulse 2", strong_pu, 8'h00);
    write_port(8'h0E, 8'h0E);
    check8("R4 multi-bit pulse", strong_pu, 8'h0E);
    repeat (2) @(negedge clk);
    check8("R4 multi-bit end", strong_pu, 8'h00);
    check8("R2 all weak", weak_pu, 8'hFF);
  endtask

  task automatic t_cancel;
    write_port(8'h04, 8'h00);
    write_port(8'h04, 8'h04);
    check8("R4 pulse start", strong_pu, 8'h04);
    write_port(8'h04, 8'h00);
    check8("R11 pulse cut", strong_pu, 8'h00);
    check8("R11 pd takes over", strong_pd, 8'h04);
    write_port(8'h04, 8'h04);
    repeat (3) @(negedge clk);
    check8("R11 restored", strong_pu, 8'h00);
  endtask

  task automatic t_input;
    pad_in = 8'hA5;
    @(negedge clk);
    check8("R7 pin_rd delayed", pin_rd, 8'hFF);
    @(negedge clk);
    check8("R7 pin_rd follows pad", pin_rd, 8'hA5);
    check8("R7 latch unchanged", latch_rd, 8'hFF);
    check8("R2 weak only input", weak_pu, 8'hFF);
    check8("R10 odd falling", pin_evt, 8'h0A);
    @(negedge clk);
    check8("R10 single cycle", pin_evt, 8'h00);
    pad_in = 8'hFF;
    repeat (2) @(negedge clk);
    check8("R10 even rising", pin_evt, 8'h50);
    @(negedge clk);
    check8("R10 rise single", pin_evt, 8'h00);
  endtask

  task automatic t_alt;
    alt_en = 8'h01; alt_out = 8'h00;
    #1;
    check8("R9 alt low pd", strong_pd, 8'h01);
    @(negedge clk);
    alt_out = 8'h01;
    #1;
    check8("R9 alt rise pulse 1", strong_pu, 8'h01);
    @(negedge clk);
    check8("R9 alt rise pulse 2", strong_pu, 8'h01);
    @(negedge clk);
    check8("R9 alt pulse end", strong_pu, 8'h00);
    write_port(8'h01, 8'h00);
    check8("R9 latch low wins", strong_pd, 8'h01);
    alt_en = 8'h00;
    write_port(8'h01, 8'h01);
    repeat (3) @(negedge clk);
    check8("R9 restored", weak_pu, 8'hFF);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_mask = '0; wr_data = '0;
    alt_en = '0; alt_out = '0; pad_in = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_low();
    t_pulse();
    t_no_pulse();
    t_cancel();
    t_input();
    t_alt();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule